// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

This block is the data path of a synchronous serial master. It accepts one transfer command at a time and runs it on three pins: a serial clock (`sck`), a serial data output (`sdo`) and a serial data input (`sdi`). A command can write, read, or do both at once (full duplex). It moves either a run of whole bytes or a single group of 1 to 8 bits. Each command picks its own bit order, the clock edge on which output data changes and the clock edge on which input data is captured.

Outgoing bytes come from a valid/ready input stream and received bytes leave on a valid/ready output stream. An external clock generator supplies `tick`, a strobe that marks each half period of the serial clock. The engine advances the serial clock only on a tick, and only while it has everything it needs to finish the current byte, so no data is ever lost. A loopback switch feeds the engine's own output back into its capture path for self-test.

Top module: `ssx_engine`

## Requirements
- R1: After reset `sck` and `sdo` are low, `rx_valid` and `tx_ready` are low and `cmd_ready` is high.
- R2: `sck` idles low and changes only in the cycle after a `tick`. Each bit takes one full `sck` period: a rising edge on one tick and a falling edge on the next.
- R3: With `cmd_drive_rise` = 0, `sdo` is set up before the first rising edge and changes only on falling edges. With `cmd_drive_rise` = 1, `sdo` changes only on rising edges.
- R4: With `cmd_sample_fall` = 0, input bits are captured on rising `sck` edges. With `cmd_sample_fall` = 1, they are captured on falling edges.
- R5: With `cmd_lsb_first` = 0, bit 7 of a byte goes first on the wire. With `cmd_lsb_first` = 1, bit 0 goes first. The same order applies to received bytes.
- R6: In byte mode, `cmd_len_m1` holds the byte count minus one. A value of 0 moves exactly one byte and 65535 moves 65536 bytes. The command consumes and returns exactly that many bytes.
- R7: A full-duplex command returns exactly one received byte for each byte sent. Under loopback, each received byte equals the byte sent.
- R8: In bit mode (`cmd_bit_mode` = 1), `cmd_nbits_m1` holds the bit count minus one. The engine sends the low n bits of one input byte and returns one byte.
- R9: In bit mode, MSB-first input is right-justified: the first bit received lands at bit n-1. LSB-first input is left-justified: the first bit received lands at bit 8-n. All other result bits are zero.
- R10: A read-only command holds `sdo` low and takes no byte from the input stream.
- R11: A write-only command returns no byte on the output stream.
- R12: With `loop_en` = 1, the capture path takes `sdo` and ignores `sdi`. With `loop_en` = 0, it takes `sdi`.
- R13: A byte starts only when an input byte is present (for writes) and the result holding slot is empty (for reads). While waiting, `sck` stays low, and a result that is not accepted is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Half-period strobe from the clock generator |
| loop_en | input | 1 | Routes `sdo` internally to the capture path |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and accepting a command |
| cmd_write | input | 1 | Command drives data out |
| cmd_read | input | 1 | Command captures data in |
| cmd_bit_mode | input | 1 | 1: bit transfer, 0: byte transfer |
| cmd_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cmd_drive_rise | input | 1 | 1: drive on rising edge, 0: drive on falling edge |
| cmd_sample_fall | input | 1 | 1: capture on falling edge, 0: capture on rising edge |
| cmd_len_m1 | input | 16 | Byte count minus one |
| cmd_nbits_m1 | input | 3 | Bit count minus one (bit mode) |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte present |
| tx_ready | output | 1 | Outgoing byte taken this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte present |
| rx_ready | input | 1 | Consumer takes the received byte |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in, already synchronous to `clk` |
| busy | output | 1 | A command is in progress |

## Verification
The assertions assume that `sdi` is synchronous to `clk` and that command fields are stable while `cmd_valid` is high. They also assume that a loopback command never drives and samples on the same edge, because in that case the capture sees the bit from before that edge. The bench drives every input on the falling edge of `clk`. It models the serial device from the `sck` level seen once per cycle, changing `sdi` on the edge opposite the capture edge and capturing `sdo` on the edge opposite the drive edge. Every loopback case uses edge pairs that differ.

// File: rtl/ssx_pkg.sv
// Package: shared types for the serial shift engine.
// Assumes: nothing; types only.
package ssx_pkg;

    // Sequencer states; LOAD waits for stream resources, PRIME gives a
    // one-cycle slot to set up the first bit before any clock edge.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PRIME = 2'd2,
        ST_SHIFT = 2'd3
    } ssx_state_e;

    // Per-command transfer options latched at command accept.
    typedef struct packed {
        logic wr;
        logic rd;
        logic bit_mode;
        logic lsb_first;
        logic drv_rise;
        logic smp_fall;
    } ssx_mode_t;

endpackage

// File: rtl/ssx_ctrl.sv
// Module: ssx_ctrl
// Sequences one command: latches its options, gates each byte (or bit
// group) on stream resources, toggles the serial clock on clock-generator
// ticks and produces drive/sample/done events for the shifters.
// Assumes: tick is a single-cycle strobe per half period; command fields
// are stable while cmd_valid is high.
module ssx_ctrl
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  ssx_mode_t         cmd_mode,
    input  logic [LEN_W-1:0]  cmd_len_m1,
    input  logic [CNT_W-1:0]  cmd_nbits_m1,
    input  logic              tx_avail,
    input  logic              rx_free,
    output logic              cmd_ready,
    output ssx_state_e        state,
    output ssx_mode_t         mode,
    output logic [CNT_W-1:0]  nbits_m1,
    output logic              unit_load,
    output logic              drive_ev,
    output logic              sample_ev,
    output logic              unit_done,
    output logic              sck
);

    ssx_state_e       state_q;
    ssx_mode_t        mode_q;
    logic [LEN_W-1:0] len_left_q;
    logic [CNT_W-1:0] nbits_q;
    logic [CNT_W-1:0] bit_left_q;
    logic             sck_q;
    logic             rise_ev;
    logic             fall_ev;
    logic             last_bit;

    // Event decode: resource gate, clock edges, drive and capture moments.
    always_comb begin
        unit_load = (state_q == ST_LOAD)
                    && (!mode_q.wr || tx_avail)
                    && (!mode_q.rd || rx_free);
        rise_ev   = (state_q == ST_SHIFT) && tick && !sck_q;
        fall_ev   = (state_q == ST_SHIFT) && tick && sck_q;
        last_bit  = (bit_left_q == '0);
        unit_done = fall_ev && last_bit;
        if (mode_q.drv_rise) begin
            drive_ev = rise_ev;
        end else begin
            drive_ev = (state_q == ST_PRIME) || (fall_ev && !last_bit);
        end
        sample_ev = mode_q.smp_fall ? fall_ev : rise_ev;
    end

    // Command sequencer: accept, per-unit gating, byte countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= '0;
            len_left_q <= '0;
            nbits_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        mode_q     <= cmd_mode;
                        len_left_q <= cmd_len_m1;
                        nbits_q    <= cmd_nbits_m1;
                        state_q    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (unit_load) begin
                        state_q <= ST_PRIME;
                    end
                end
                ST_PRIME: state_q <= ST_SHIFT;
                default: begin
                    if (unit_done) begin
                        if (mode_q.bit_mode || (len_left_q == '0)) begin
                            state_q <= ST_IDLE;
                        end else begin
                            len_left_q <= len_left_q - 1'b1;
                            state_q    <= ST_LOAD;
                        end
                    end
                end
            endcase
        end
    end

    // Bit countdown within the current byte or bit group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_left_q <= '0;
        end else if (unit_load) begin
            bit_left_q <= mode_q.bit_mode ? nbits_q : CNT_W'(DATA_W - 1);
        end else if (fall_ev) begin
            bit_left_q <= bit_left_q - 1'b1;
        end
    end

    // Serial clock level: rises and falls on alternate ticks while shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else if (rise_ev) begin
            sck_q <= 1'b1;
        end else if (fall_ev) begin
            sck_q <= 1'b0;
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign state     = state_q;
    assign mode      = mode_q;
    assign nbits_m1  = nbits_q;
    assign sck       = sck_q;

    // R2: the serial clock moves only one cycle after a tick.
    p_sck_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(sck_q))
        else $error("p_sck_on_tick_r2");

    // R13: while waiting for stream resources the clock is parked low.
    p_stall_sck_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> !sck_q)
        else $error("p_stall_sck_low_r13");

    // R2: the clock is low whenever no command is running.
    p_idle_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sck_q)
        else $error("p_idle_sck_low_r2");

endmodule

// File: rtl/ssx_tx_shift.sv
// Module: ssx_tx_shift
// Output shifter: loads one byte per unit, pre-aligns MSB-first bit groups
// so the first wire bit is at the top, and moves one bit to sdo per drive
// event. Read-only units load zeros and clear sdo at once.
// Assumes: load and drive never occur in the same cycle.
module ssx_tx_shift #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              write_en,
    input  logic              lsb_first,
    input  logic              bit_mode,
    input  logic [CNT_W-1:0]  nbits_m1,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drive,
    output logic              sdo
);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] load_val;
    logic [CNT_W-1:0]  pad;

    // Load value: zero for reads, left-aligned low bits for MSB-first groups.
    always_comb begin
        pad = CNT_W'(DATA_W - 1) - nbits_m1;
        if (!write_en) begin
            load_val = '0;
        end else if (bit_mode && !lsb_first) begin
            load_val = load_data << pad;
        end else begin
            load_val = load_data;
        end
    end

    // Shift register and output bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            sdo  <= 1'b0;
        end else if (load) begin
            sr_q <= load_val;
            if (!write_en) begin
                sdo <= 1'b0;
            end
        end else if (drive) begin
            sdo  <= lsb_first ? sr_q[0] : sr_q[DATA_W-1];
            sr_q <= lsb_first ? (sr_q >> 1) : (sr_q << 1);
        end
    end

endmodule

// File: rtl/ssx_rx_shift.sv
// Module: ssx_rx_shift
// Capture shifter: inserts the input bit at the low end (MSB-first) or the
// high end (LSB-first) on each sample event, which right- or left-justifies
// partial groups. Exposes the value including this cycle's sample.
// Assumes: din is synchronous to clk.
module ssx_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    input  logic              lsb_first,
    output logic [DATA_W-1:0] cap_next
);

    logic [DATA_W-1:0] sr_q;

    // Next capture value with the current sample folded in.
    always_comb begin
        if (!sample) begin
            cap_next = sr_q;
        end else if (lsb_first) begin
            cap_next = {din, sr_q[DATA_W-1:1]};
        end else begin
            cap_next = {sr_q[DATA_W-2:0], din};
        end
    end

    // Capture register, cleared at the start of each unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clear) begin
            sr_q <= '0;
        end else begin
            sr_q <= cap_next;
        end
    end

endmodule

// File: rtl/ssx_engine.sv
// Module: ssx_engine (top)
// Serial shift engine: sequencer, output and capture shifters, loopback
// selection and a one-entry result slot on the output stream.
// Assumes: sdi is already synchronous to clk; tick comes from an external
// clock generator; loopback commands use differing drive and sample edges.
module ssx_engine
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      loop_en,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic                      cmd_write,
    input  logic                      cmd_read,
    input  logic                      cmd_bit_mode,
    input  logic                      cmd_lsb_first,
    input  logic                      cmd_drive_rise,
    input  logic                      cmd_sample_fall,
    input  logic [LEN_W-1:0]          cmd_len_m1,
    input  logic [$clog2(DATA_W)-1:0] cmd_nbits_m1,
    input  logic [DATA_W-1:0]         tx_data,
    input  logic                      tx_valid,
    output logic                      tx_ready,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      rx_valid,
    input  logic                      rx_ready,
    output logic                      sck,
    output logic                      sdo,
    input  logic                      sdi,
    output logic                      busy
);

    localparam int CNT_W = $clog2(DATA_W);

    ssx_mode_t         cmd_mode;
    ssx_mode_t         mode;
    ssx_state_e        state;
    logic [CNT_W-1:0]  nbits_m1;
    logic              unit_load;
    logic              drive_ev;
    logic              sample_ev;
    logic              unit_done;
    logic              din;
    logic [DATA_W-1:0] cap_next;
    logic [DATA_W-1:0] rx_data_q;
    logic              rx_valid_q;

    // Command option bundle.
    always_comb begin
        cmd_mode.wr        = cmd_write;
        cmd_mode.rd        = cmd_read;
        cmd_mode.bit_mode  = cmd_bit_mode;
        cmd_mode.lsb_first = cmd_lsb_first;
        cmd_mode.drv_rise  = cmd_drive_rise;
        cmd_mode.smp_fall  = cmd_sample_fall;
    end

    ssx_ctrl #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cmd_valid    (cmd_valid),
        .cmd_mode     (cmd_mode),
        .cmd_len_m1   (cmd_len_m1),
        .cmd_nbits_m1 (cmd_nbits_m1),
        .tx_avail     (tx_valid),
        .rx_free      (!rx_valid_q),
        .cmd_ready    (cmd_ready),
        .state        (state),
        .mode         (mode),
        .nbits_m1     (nbits_m1),
        .unit_load    (unit_load),
        .drive_ev     (drive_ev),
        .sample_ev    (sample_ev),
        .unit_done    (unit_done),
        .sck          (sck)
    );

    ssx_tx_shift #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (unit_load),
        .write_en  (mode.wr),
        .lsb_first (mode.lsb_first),
        .bit_mode  (mode.bit_mode),
        .nbits_m1  (nbits_m1),
        .load_data (tx_data),
        .drive     (drive_ev),
        .sdo       (sdo)
    );

    // Capture source: own output under loopback, else the input pin.
    assign din = loop_en ? sdo : sdi;

    ssx_rx_shift #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (unit_load),
        .sample    (sample_ev),
        .din       (din),
        .lsb_first (mode.lsb_first),
        .cap_next  (cap_next)
    );

    // Result slot: filled at the end of a read unit, emptied by the consumer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            if (rx_valid_q && rx_ready) begin
                rx_valid_q <= 1'b0;
            end
            if (unit_done && mode.rd) begin
                rx_valid_q <= 1'b1;
                rx_data_q  <= cap_next;
            end
        end
    end

    assign tx_ready = unit_load && mode.wr;
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;
    assign busy     = (state != ST_IDLE);

    // R3: drive on falling edge means sdo holds across every rising edge.
    p_hold_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.drv_rise && $rose(sck)) |-> $stable(sdo))
        else $error("p_hold_on_rise_r3");

    // R3: drive on rising edge means sdo holds across every falling edge.
    p_hold_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.drv_rise && $fell(sck)) |-> $stable(sdo))
        else $error("p_hold_on_fall_r3");

    // R10: a read-only command keeps the data line low once it is set up.
    p_read_sdo_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.wr && (state == ST_PRIME || state == ST_SHIFT)) |-> !sdo)
        else $error("p_read_sdo_low_r10");

    // R11: results appear only for commands that read.
    p_result_needs_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid_q) |-> mode.rd)
        else $error("p_result_needs_read_r11");

    // R13: an unaccepted result is held unchanged.
    p_result_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_q && !rx_ready) |=> (rx_valid_q && $stable(rx_data_q)))
        else $error("p_result_held_r13");

endmodule

// File: tb/ssx_engine_bench.sv
`timescale 1ns/1ps
module ssx_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        loop_en = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0, cmd_read = 1'b0, cmd_bit_mode = 1'b0;
    logic        cmd_lsb_first = 1'b0, cmd_drive_rise = 1'b0, cmd_sample_fall = 1'b0;
    logic [15:0] cmd_len_m1 = '0;
    logic [2:0]  cmd_nbits_m1 = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        sck, sdo;
    logic        sdi = 1'b0;
    logic        busy;

    ssx_engine u_ssx_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick), .loop_en(loop_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_bit_mode(cmd_bit_mode),
        .cmd_lsb_first(cmd_lsb_first), .cmd_drive_rise(cmd_drive_rise),
        .cmd_sample_fall(cmd_sample_fall), .cmd_len_m1(cmd_len_m1),
        .cmd_nbits_m1(cmd_nbits_m1), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .sck(sck), .sdo(sdo), .sdi(sdi), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    logic [7:0] tx_q[$];
    logic [7:0] exp_rx_q[$];
    logic       dev_exp_q[$];
    logic       dev_drv_q[$];
    logic       dev_cap_fall = 1'b0;
    logic       dev_drv_on_rise = 1'b0;
    logic       dev_cap_en = 1'b0;
    logic       rx_hold = 1'b0;
    logic       tx_gate = 1'b0;
    logic       prev_sck = 1'b0;
    int         tick_div = 1;
    int         tick_cnt = 0;
    int         rises = 0;
    int         rx_count = 0;
    int         tx_used = 0;
    int         cycles = 0;
    string      rx_req = "R7";
    string      dev_req = "R5";

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] justify(input logic [7:0] v, input int n, input logic lsb);
        logic [7:0] m;
        m = (n == 8) ? 8'hFF : 8'((9'd1 << n) - 9'd1);
        return lsb ? 8'((v & m) << (8 - n)) : (v & m);
    endfunction

    // Push the wire order of the low n bits of v onto a bit queue.
    task automatic wire_bits(input logic [7:0] v, input int n, input logic lsb, input bit to_exp);
        for (int i = 0; i < n; i++) begin
            if (to_exp) dev_exp_q.push_back(lsb ? v[i] : v[n-1-i]);
            else        dev_drv_q.push_back(lsb ? v[i] : v[n-1-i]);
        end
    endtask

    // Stimulus and monitor process: drive at the falling clock edge, then judge handshakes.
    always begin
        @(negedge clk);
        cycles++;
        tick = (tick_cnt == 0);
        tick_cnt = (tick_cnt + 1) % tick_div;
        rx_ready = !rx_hold;
        if (!tx_gate && tx_q.size() > 0) begin
            tx_valid = 1'b1;
            tx_data  = tx_q[0];
        end else begin
            tx_valid = 1'b0;
        end
        // Serial device model, driven from the observed clock level.
        if (sck && !prev_sck) begin
            rises++;
            if (dev_cap_en && !dev_cap_fall) begin
                if (dev_exp_q.size() == 0) check(dev_req, 32'(sdo), 32'h2);
                else check(dev_req, 32'(sdo), 32'(dev_exp_q.pop_front()));
            end
            if (dev_drv_on_rise) sdi = (dev_drv_q.size() > 0) ? dev_drv_q.pop_front() : 1'b0;
        end
        if (!sck && prev_sck) begin
            if (dev_cap_en && dev_cap_fall) begin
                if (dev_exp_q.size() == 0) check(dev_req, 32'(sdo), 32'h2);
                else check(dev_req, 32'(sdo), 32'(dev_exp_q.pop_front()));
            end
            if (!dev_drv_on_rise) sdi = (dev_drv_q.size() > 0) ? dev_drv_q.pop_front() : 1'b0;
        end
        prev_sck = sck;
        #1;
        if (tx_valid && tx_ready) begin
            void'(tx_q.pop_front());
            tx_used++;
        end
        if (rx_valid && rx_ready) begin
            rx_count++;
            if (exp_rx_q.size() == 0) begin
                check({rx_req, " unexpected result"}, 32'(rx_data), 32'h100);
            end else begin
                check(rx_req, 32'(rx_data), 32'(exp_rx_q.pop_front()));
            end
        end
    end

    task automatic send_cmd(input logic wr, input logic rd, input logic bm, input logic lsb,
                            input logic dr, input logic sf, input int len_m1, input int nb_m1);
        dev_cap_fall    = dr;
        dev_drv_on_rise = sf;
        if (!sf && dev_drv_q.size() > 0) sdi = dev_drv_q.pop_front();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_write = wr; cmd_read = rd; cmd_bit_mode = bm; cmd_lsb_first = lsb;
        cmd_drive_rise = dr; cmd_sample_fall = sf;
        cmd_len_m1 = 16'(len_m1); cmd_nbits_m1 = 3'(nb_m1);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        repeat (3) @(negedge clk);
        while (busy || exp_rx_q.size() > 0 || dev_exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        dev_cap_en = 1'b0;
        dev_drv_q.delete();
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        while (cycles < 150000) @(negedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rc0, tu0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 sck", 32'(sck), 0);
        check("R1 sdo", 32'(sdo), 0);
        check("R1 rx_valid", 32'(rx_valid), 0);
        check("R1 cmd_ready", 32'(cmd_ready), 1);
        check("R1 tx_ready", 32'(tx_ready), 0);

        // R3 R5 R6 R11: write-only bytes, MSB first, drive on falling edge
        dev_req = "R5 msb write"; rc0 = rx_count; tu0 = tx_used;
        tx_q = '{8'hA5, 8'h3C, 8'hF0};
        foreach (tx_q[i]) wire_bits(tx_q[i], 8, 1'b0, 1'b1);
        dev_cap_en = 1'b1;
        send_cmd(1, 0, 0, 0, 0, 0, 2, 0);
        wait_done();
        check("R11 no results", 32'(rx_count - rc0), 0);
        check("R6 bytes taken", 32'(tx_used - tu0), 3);

        // R3 R5: write-only, LSB first, drive on rising edge
        dev_req = "R3 lsb write rise";
        tx_q = '{8'h81, 8'h6E};
        foreach (tx_q[i]) wire_bits(tx_q[i], 8, 1'b1, 1'b1);
        dev_cap_en = 1'b1;
        send_cmd(1, 0, 0, 1, 1, 0, 1, 0);
        wait_done();

        // R4 R10: read-only MSB first, capture on rising edge, sdo held low
        rx_req = "R4 read rise"; dev_req = "R10 sdo low"; tu0 = tx_used;
        wire_bits(8'hC3, 8, 1'b0, 1'b0); wire_bits(8'h5A, 8, 1'b0, 1'b0);
        exp_rx_q = '{8'hC3, 8'h5A};
        for (int i = 0; i < 16; i++) dev_exp_q.push_back(1'b0);
        dev_cap_en = 1'b1;
        send_cmd(0, 1, 0, 0, 0, 0, 1, 0);
        wait_done();
        check("R10 no bytes taken", 32'(tx_used - tu0), 0);

        // R4 R5 R12: read-only LSB first, capture on falling edge, loopback off
        rx_req = "R4 read fall lsb";
        wire_bits(8'h1E, 8, 1'b1, 1'b0); wire_bits(8'hB7, 8, 1'b1, 1'b0);
        exp_rx_q = '{8'h1E, 8'hB7};
        send_cmd(0, 1, 0, 1, 0, 1, 1, 0);
        wait_done();

        // R7 R12: full duplex under loopback, sdi held high must be ignored
        loop_en = 1'b1; rx_req = "R12 loopback duplex"; rc0 = rx_count;
        tx_q = '{8'h12, 8'h34, 8'hAB, 8'hCD};
        exp_rx_q = '{8'h12, 8'h34, 8'hAB, 8'hCD};
        for (int i = 0; i < 40; i++) dev_drv_q.push_back(1'b1);
        send_cmd(1, 1, 0, 0, 0, 0, 3, 0);
        wait_done();
        check("R7 result count", 32'(rx_count - rc0), 4);
        loop_en = 1'b0;

        // R8: bit write, 5 bits MSB first from the low bits
        dev_req = "R8 bit write"; rc0 = rx_count;
        tx_q = '{8'hF6};
        wire_bits(8'hF6, 5, 1'b0, 1'b1);
        dev_cap_en = 1'b1;
        send_cmd(1, 0, 1, 0, 0, 0, 0, 4);
        wait_done();
        check("R8 no result on write", 32'(rx_count - rc0), 0);

        // R9: bit read 3 bits MSB first, right-justified
        rx_req = "R9 right-justified";
        wire_bits(8'h05, 3, 1'b0, 1'b0);
        exp_rx_q = '{justify(8'h05, 3, 1'b0)};
        send_cmd(0, 1, 1, 0, 0, 0, 0, 2);
        wait_done();

        // R9: bit read 3 bits LSB first, left-justified
        rx_req = "R9 left-justified";
        wire_bits(8'h03, 3, 1'b1, 1'b0);
        exp_rx_q = '{justify(8'h03, 3, 1'b1)};
        send_cmd(0, 1, 1, 1, 0, 1, 0, 2);
        wait_done();

        // R8 R9: loopback bit transfer, 6 bits LSB first, drive rise / sample fall
        loop_en = 1'b1; rx_req = "R9 loopback 6 bits";
        tx_q = '{8'hE9};
        exp_rx_q = '{justify(8'hE9, 6, 1'b1)};
        send_cmd(1, 1, 1, 1, 1, 1, 0, 5);
        wait_done();

        // R6: length field zero moves exactly one byte
        rx_req = "R6 single byte"; rc0 = rx_count; tu0 = tx_used;
        tx_q = '{8'h77, 8'h99};
        exp_rx_q = '{8'h77};
        send_cmd(1, 1, 0, 0, 0, 0, 0, 0);
        wait_done();
        check("R6 one taken", 32'(tx_used - tu0), 1);
        check("R6 one returned", 32'(rx_count - rc0), 1);
        tx_q.delete();
        loop_en = 1'b0;

        // R13: missing input byte parks the clock low
        dev_req = "R13 write stall"; tu0 = tx_used;
        tx_q = '{8'h96};
        wire_bits(8'h96, 8, 1'b0, 1'b1); wire_bits(8'h69, 8, 1'b0, 1'b1);
        dev_cap_en = 1'b1;
        send_cmd(1, 0, 0, 0, 0, 0, 1, 0);
        while (tx_used == tu0) @(negedge clk);
        repeat (30) @(negedge clk);
        r0 = rises;
        repeat (30) @(negedge clk);
        check("R13 no clocks while starved", 32'(rises - r0), 0);
        check("R13 sck low", 32'(sck), 0);
        check("R13 still busy", 32'(busy), 1);
        tx_q.push_back(8'h69);
        wait_done();

        // R13: full result slot stalls the transfer without loss, slow ticks
        loop_en = 1'b1; tick_div = 3; rx_req = "R13 result stall"; rx_hold = 1'b1;
        tx_q = '{8'h5C, 8'hE1, 8'h0F};
        exp_rx_q = '{8'h5C, 8'hE1, 8'h0F};
        send_cmd(1, 1, 0, 1, 0, 0, 2, 0);
        repeat (100) @(negedge clk);
        r0 = rises;
        check("R13 result held valid", 32'(rx_valid), 1);
        check("R13 first result held", 32'(rx_data), 32'h5C);
        repeat (50) @(negedge clk);
        check("R13 no clocks while full", 32'(rises - r0), 0);
        rx_hold = 1'b0;
        wait_done();
        tick_div = 1;

        // R6 R7: long loopback run beyond an 8-bit count
        rx_req = "R6 long run"; rc0 = rx_count;
        for (int i = 0; i < 260; i++) begin
            tx_q.push_back(8'(i * 7 + 3));
            exp_rx_q.push_back(8'(i * 7 + 3));
        end
        send_cmd(1, 1, 0, 0, 0, 0, 259, 0);
        wait_done();
        check("R6 long count", 32'(rx_count - rc0), 260);
        loop_en = 1'b0;

        check("R2 sck idle low", 32'(sck), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule